// File: doc/BRIEF.md
# Raster Timing Generator with Key-Gated Timing Registers

This block produces horizontal and vertical video timing for a display controller. Two down-counters do the work. The pixel counter runs from the horizontal total to zero and then reloads. The line counter steps once each time the pixel counter wraps. Each axis has three window outputs: sync, blank and active. Each window is decoded by comparing its counter with a programmable start/stop pair. Software computes each total as active size plus leading margin, trailing margin and sync length, minus one.

- The sync pair runs from the total down to the total minus the sync length.
- The blank and active pairs run from the total minus sync length minus leading margin down to the trailing margin minus one.

All timing registers sit behind a lock gate. A key word written to the key register opens the gate for exactly one following bus access. A lock state machine has two states, SHUT and OPEN, and these transitions:

- SHUT to OPEN on a key write.
- OPEN to OPEN on a further key write.
- OPEN to SHUT on any other read or write.
- SHUT to SHUT otherwise.

A scan state machine has two states, IDLE and RUN. It moves from IDLE to RUN while the enable bit is set and from RUN to IDLE while it is clear. In IDLE both counters are held at their totals and all window outputs are low.

Top module: `raster_timing_gen`

## Requirements
- R1: After reset every register reads 0, the gate is SHUT and all six window outputs are low.
- R2: A write to any timing or control register while the gate is SHUT is ignored without error, and the register reads back unchanged.
- R3: Writing 0x000000AA to the key register (address 9) opens the gate for exactly one following access. While open, the key register reads 1 in bit 0. Any non-key read or write closes the gate, including a read that returns that 1.
- R4: A write of any other value to the key register does not open the gate.
- R5: Register map by word address: 0 horizontal total, 1 horizontal sync pair, 2 horizontal blank pair, 3 horizontal active pair, 4 vertical total, 5 vertical sync pair, 6 vertical blank pair, 7 vertical active pair, 8 control (bit 0 enable), 9 key. Each pair holds start in bits 15:0 and stop in bits 31:16. Read data appears on the cycle after the read strobe.
- R6: While enable is 0 the six outputs go low on the next cycle and the counters are held at their totals.
- R7: When running, the pixel counter decrements each cycle and reloads to the horizontal total on the cycle after it reaches zero. The first running cycle shows the total.
- R8: The line counter decrements only on the cycle after the pixel counter is zero, and reloads to the vertical total after zero.
- R9: A window output is high exactly when its counter is at most the pair's start and strictly greater than its stop. Outputs are ordered sync, blank, active per axis.
- R10: With pairs programmed by the formulas, each line holds sync for the sync length and active for the active width, and each frame has active-width times active-height cycles where both active outputs are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr_i | input | 1 | Write strobe |
| bus_rd_i | input | 1 | Read strobe |
| bus_addr_i | input | 4 | Word address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid the cycle after the read strobe |
| h_sync_o | output | 1 | Horizontal sync window |
| h_blank_o | output | 1 | Horizontal blank window |
| h_active_o | output | 1 | Horizontal active window |
| v_sync_o | output | 1 | Vertical sync window |
| v_blank_o | output | 1 | Vertical blank window |
| v_active_o | output | 1 | Vertical active window |

## Verification
The hardest case is the one-shot gate being consumed by an intervening access. The stimulus opens the gate, then spends it on a read of another register, and then attempts a protected write. Readback must show that write had no effect. A separate sequence reads the key register twice after one key write, so the bus shows the gate as open and then as closed. Timing is checked per cycle against a model of the counters across two full frames in each of two modes. The design is disabled between the modes, so the restart from the totals is exercised as well.

// File: rtl/rtg_pkg.sv
package rtg_pkg;
    localparam int ADDR_W   = 4;
    localparam int DATA_W   = 32;
    localparam int CNT_W    = DATA_W / 2;
    localparam int WIN_N    = 3;
    localparam int WIN_SYNC   = 0;
    localparam int WIN_BLANK  = 1;
    localparam int WIN_ACTIVE = 2;

    typedef logic [ADDR_W-1:0] rtg_addr_t;

    localparam rtg_addr_t RA_HTOTAL  = 4'd0;
    localparam rtg_addr_t RA_HSYNC   = 4'd1;
    localparam rtg_addr_t RA_HBLANK  = 4'd2;
    localparam rtg_addr_t RA_HACTIVE = 4'd3;
    localparam rtg_addr_t RA_VTOTAL  = 4'd4;
    localparam rtg_addr_t RA_VSYNC   = 4'd5;
    localparam rtg_addr_t RA_VBLANK  = 4'd6;
    localparam rtg_addr_t RA_VACTIVE = 4'd7;
    localparam rtg_addr_t RA_CTRL    = 4'd8;
    localparam rtg_addr_t RA_KEY     = 4'd9;

    localparam logic [DATA_W-1:0] KEY_WORD = 32'h0000_00AA;

    // stop in the upper half, start in the lower half
    typedef struct packed {
        logic [CNT_W-1:0] stop;
        logic [CNT_W-1:0] start;
    } rtg_pair_t;

    typedef enum logic {LK_SHUT, LK_OPEN} rtg_lock_e;
    typedef enum logic {TG_IDLE, TG_RUN}  rtg_scan_e;
endpackage

// File: rtl/rtg_regs.sv
module rtg_regs
    import rtg_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_i,
    input  logic                    rd_i,
    input  rtg_addr_t               addr_i,
    input  logic [DATA_W-1:0]       wdata_i,
    output logic [DATA_W-1:0]       rdata_o,
    output logic [CNT_W-1:0]        htotal_o,
    output logic [CNT_W-1:0]        vtotal_o,
    output rtg_pair_t [WIN_N-1:0]   hwin_o,
    output rtg_pair_t [WIN_N-1:0]   vwin_o,
    output logic                    enable_o,
    output logic                    gate_open_o
);
    rtg_lock_e lk_q, lk_d;
    logic      key_wr;
    logic      any_access;
    logic      wr_ok;

    logic [CNT_W-1:0]      htotal_q, vtotal_q;
    rtg_pair_t [WIN_N-1:0] hwin_q, vwin_q;
    logic                  enable_q;

    assign key_wr     = wr_i && (addr_i == RA_KEY) && (wdata_i == KEY_WORD);
    assign any_access = wr_i || rd_i;

    // lock state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lk_q <= LK_SHUT;
        else        lk_q <= lk_d;
    end

    // lock next state
    always_comb begin
        lk_d = lk_q;
        unique case (lk_q)
            LK_SHUT: lk_d = key_wr ? LK_OPEN : LK_SHUT;
            LK_OPEN: begin
                if (key_wr)          lk_d = LK_OPEN;
                else if (any_access) lk_d = LK_SHUT;
                else                 lk_d = LK_OPEN;
            end
        endcase
    end

    assign wr_ok = wr_i && (lk_q == LK_OPEN) && !key_wr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            htotal_q <= '0;
            vtotal_q <= '0;
            hwin_q   <= '0;
            vwin_q   <= '0;
            enable_q <= 1'b0;
        end else if (wr_ok) begin
            case (addr_i)
                RA_HTOTAL:  htotal_q           <= wdata_i[CNT_W-1:0];
                RA_HSYNC:   hwin_q[WIN_SYNC]   <= wdata_i;
                RA_HBLANK:  hwin_q[WIN_BLANK]  <= wdata_i;
                RA_HACTIVE: hwin_q[WIN_ACTIVE] <= wdata_i;
                RA_VTOTAL:  vtotal_q           <= wdata_i[CNT_W-1:0];
                RA_VSYNC:   vwin_q[WIN_SYNC]   <= wdata_i;
                RA_VBLANK:  vwin_q[WIN_BLANK]  <= wdata_i;
                RA_VACTIVE: vwin_q[WIN_ACTIVE] <= wdata_i;
                RA_CTRL:    enable_q           <= wdata_i[0];
                default:    ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_o <= '0;
        end else if (rd_i) begin
            case (addr_i)
                RA_HTOTAL:  rdata_o <= DATA_W'(htotal_q);
                RA_HSYNC:   rdata_o <= hwin_q[WIN_SYNC];
                RA_HBLANK:  rdata_o <= hwin_q[WIN_BLANK];
                RA_HACTIVE: rdata_o <= hwin_q[WIN_ACTIVE];
                RA_VTOTAL:  rdata_o <= DATA_W'(vtotal_q);
                RA_VSYNC:   rdata_o <= vwin_q[WIN_SYNC];
                RA_VBLANK:  rdata_o <= vwin_q[WIN_BLANK];
                RA_VACTIVE: rdata_o <= vwin_q[WIN_ACTIVE];
                RA_CTRL:    rdata_o <= DATA_W'(enable_q);
                RA_KEY:     rdata_o <= DATA_W'(lk_q == LK_OPEN);
                default:    rdata_o <= '0;
            endcase
        end
    end

    assign htotal_o    = htotal_q;
    assign vtotal_o    = vtotal_q;
    assign hwin_o      = hwin_q;
    assign vwin_o      = vwin_q;
    assign enable_o    = enable_q;
    assign gate_open_o = (lk_q == LK_OPEN);
endmodule

// File: rtl/rtg_scan.sv
module rtg_scan
    import rtg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable_i,
    input  logic [CNT_W-1:0] htotal_i,
    input  logic [CNT_W-1:0] vtotal_i,
    output logic [CNT_W-1:0] hcnt_o,
    output logic [CNT_W-1:0] vcnt_o,
    output logic             run_o
);
    rtg_scan_e st_q, st_d;
    logic [CNT_W-1:0] hcnt_q, vcnt_q;
    logic             h_wrap;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= TG_IDLE;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            TG_IDLE: st_d = enable_i ? TG_RUN  : TG_IDLE;
            TG_RUN:  st_d = enable_i ? TG_RUN  : TG_IDLE;
        endcase
    end

    assign h_wrap = (hcnt_q == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hcnt_q <= '0;
            vcnt_q <= '0;
        end else begin
            unique case (st_q)
                TG_IDLE: begin
                    hcnt_q <= htotal_i;
                    vcnt_q <= vtotal_i;
                end
                TG_RUN: begin
                    if (h_wrap) begin
                        hcnt_q <= htotal_i;
                        vcnt_q <= (vcnt_q == '0) ? vtotal_i : vcnt_q - 1'b1;
                    end else begin
                        hcnt_q <= hcnt_q - 1'b1;
                    end
                end
            endcase
        end
    end

    assign hcnt_o = hcnt_q;
    assign vcnt_o = vcnt_q;
    assign run_o  = (st_q == TG_RUN);
endmodule

// File: rtl/rtg_window.sv
module rtg_window
    import rtg_pkg::*;
(
    input  logic             run_i,
    input  logic [CNT_W-1:0] cnt_i,
    input  rtg_pair_t        pair_i,
    output logic             hit_o
);
    logic below_start, above_stop;

    assign below_start = (cnt_i <= pair_i.start);
    assign above_stop  = (cnt_i >  pair_i.stop);
    assign hit_o       = run_i && below_start && above_stop;
endmodule

// File: rtl/raster_timing_gen.sv
module raster_timing_gen
    import rtg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr_i,
    input  logic              bus_rd_i,
    input  logic [3:0]        bus_addr_i,
    input  logic [31:0]       bus_wdata_i,
    output logic [31:0]       bus_rdata_o,
    output logic              h_sync_o,
    output logic              h_blank_o,
    output logic              h_active_o,
    output logic              v_sync_o,
    output logic              v_blank_o,
    output logic              v_active_o
);
    logic [CNT_W-1:0]      htotal, vtotal, hcnt, vcnt;
    rtg_pair_t [WIN_N-1:0] hwin, vwin;
    logic                  enable, gate_open, run;
    logic [WIN_N-1:0]      h_hit, v_hit;

    rtg_regs u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_i        (bus_wr_i),
        .rd_i        (bus_rd_i),
        .addr_i      (bus_addr_i),
        .wdata_i     (bus_wdata_i),
        .rdata_o     (bus_rdata_o),
        .htotal_o    (htotal),
        .vtotal_o    (vtotal),
        .hwin_o      (hwin),
        .vwin_o      (vwin),
        .enable_o    (enable),
        .gate_open_o (gate_open)
    );

    rtg_scan u_scan (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable_i (enable),
        .htotal_i (htotal),
        .vtotal_i (vtotal),
        .hcnt_o   (hcnt),
        .vcnt_o   (vcnt),
        .run_o    (run)
    );

    for (genvar w = 0; w < WIN_N; w++) begin : g_win
        rtg_window u_h (
            .run_i  (run),
            .cnt_i  (hcnt),
            .pair_i (hwin[w]),
            .hit_o  (h_hit[w])
        );
        rtg_window u_v (
            .run_i  (run),
            .cnt_i  (vcnt),
            .pair_i (vwin[w]),
            .hit_o  (v_hit[w])
        );
    end

    assign h_sync_o   = h_hit[WIN_SYNC];
    assign h_blank_o  = h_hit[WIN_BLANK];
    assign h_active_o = h_hit[WIN_ACTIVE];
    assign v_sync_o   = v_hit[WIN_SYNC];
    assign v_blank_o  = v_hit[WIN_BLANK];
    assign v_active_o = v_hit[WIN_ACTIVE];
endmodule

// File: rtl/rtg_checker.sv
module rtg_checker
    import rtg_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             wr,
    input logic             rd,
    input logic [3:0]       addr,
    input logic [31:0]      wdata,
    input logic             gate_open,
    input logic             enable,
    input logic             run,
    input logic [CNT_W-1:0] htotal,
    input logic [CNT_W-1:0] hcnt,
    input logic [CNT_W-1:0] vcnt,
    input logic [5:0]       outs
);
    logic key_write;
    assign key_write = wr && (addr == RA_KEY) && (wdata == KEY_WORD);

    AST_GATE_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_open && (wr || rd) && !key_write) |=> !gate_open); // R3
    AST_LOCKED_WRITE_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (!gate_open && wr && addr == RA_HTOTAL) |=> $stable(htotal)); // R2
    AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (outs == 6'b0)); // R6
    AST_HCNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (run && hcnt != '0) |=> (hcnt == $past(hcnt) - 1'b1)); // R7
    AST_VCNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (run && hcnt != '0) |=> $stable(vcnt)); // R8
    AST_VCNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (run && hcnt == '0 && vcnt != '0) |=> (vcnt == $past(vcnt) - 1'b1)); // R8
endmodule

bind raster_timing_gen rtg_checker chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr        (bus_wr_i),
    .rd        (bus_rd_i),
    .addr      (bus_addr_i),
    .wdata     (bus_wdata_i),
    .gate_open (gate_open),
    .enable    (enable),
    .run       (run),
    .htotal    (htotal),
    .hcnt      (hcnt),
    .vcnt      (vcnt),
    .outs      ({h_sync_o, h_blank_o, h_active_o, v_sync_o, v_blank_o, v_active_o})
);

// File: tb/raster_timing_gen_tb_top.sv
`timescale 1ns/1ps
module raster_timing_gen_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr = 1'b0, rd = 1'b0;
    logic [3:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        hs, hb, ha, vs, vb, va;

    int n_chk = 0;
    int n_fail = 0;

    // mode held by the bench
    int m_ht, m_vt;
    int m_hs_start, m_hs_stop, m_hb_start, m_hb_stop;
    int m_vs_start, m_vs_stop, m_vb_start, m_vb_stop;

    logic [5:0] sb_q[$];
    int cyc = 0;
    int c_hs, c_ha, c_vs, c_va, c_da;

    always #2.5 clk = ~clk;

    raster_timing_gen dut_i (
        .clk(clk), .rst_n(rst_n), .bus_wr_i(wr), .bus_rd_i(rd),
        .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
        .h_sync_o(hs), .h_blank_o(hb), .h_active_o(ha),
        .v_sync_o(vs), .v_blank_o(vb), .v_active_o(va)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk); wr = 1'b1; addr = a; wdata = d;
        @(negedge clk); wr = 1'b0;
    endtask

    task automatic bus_read(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk); rd = 1'b1; addr = a;
        @(negedge clk); rd = 1'b0; d = rdata;
    endtask

    task automatic keyed_write(input logic [3:0] a, input logic [31:0] d);
        bus_write(4'd9, 32'hAA);
        bus_write(a, d);
    endtask

    function automatic logic win(input int c, input int s, input int e);
        return (c <= s) && (c > e);
    endfunction

    task automatic program_mode(input int hact, input int hl, input int hr, input int hsl,
                                input int vact, input int vu, input int vl, input int vsl);
        m_ht = hact + hl + hr + hsl - 1;
        m_vt = vact + vu + vl + vsl - 1;
        m_hs_start = m_ht;                 m_hs_stop = m_ht - hsl;
        m_hb_start = m_ht - hsl - hl;      m_hb_stop = hr - 1;
        m_vs_start = m_vt;                 m_vs_stop = m_vt - vsl;
        m_vb_start = m_vt - vsl - vu;      m_vb_stop = vl - 1;
        keyed_write(4'd0, m_ht);
        keyed_write(4'd1, {16'(m_hs_stop), 16'(m_hs_start)});
        keyed_write(4'd2, {16'(m_hb_stop), 16'(m_hb_start)});
        keyed_write(4'd3, {16'(m_hb_stop), 16'(m_hb_start)});
        keyed_write(4'd4, m_vt);
        keyed_write(4'd5, {16'(m_vs_stop), 16'(m_vs_start)});
        keyed_write(4'd6, {16'(m_vb_stop), 16'(m_vb_start)});
        keyed_write(4'd7, {16'(m_vb_stop), 16'(m_vb_start)});
    endtask

    // driver: push the expected per-cycle window vector for n cycles
    task automatic push_expect(input int n);
        int hc = m_ht;
        int vc = m_vt;
        for (int i = 0; i < n; i++) begin
            sb_q.push_back({win(hc, m_hs_start, m_hs_stop), win(hc, m_hb_start, m_hb_stop),
                            win(hc, m_hb_start, m_hb_stop), win(vc, m_vs_start, m_vs_stop),
                            win(vc, m_vb_start, m_vb_stop), win(vc, m_vb_start, m_vb_stop)});
            if (hc == 0) begin
                hc = m_ht;
                vc = (vc == 0) ? m_vt : vc - 1;
            end else begin
                hc = hc - 1;
            end
        end
    endtask

    // monitor: pop and compare between edges
    always begin
        @(posedge clk); #2;
        if (sb_q.size() > 0) begin
            logic [5:0] exp_v;
            exp_v = sb_q.pop_front();
            n_chk++;
            if ({hs, hb, ha, vs, vb, va} !== exp_v) begin
                n_fail++;
                $display("FAIL R9 R7 R8 cycle %0d actual=%b expected=%b", cyc, {hs, hb, ha, vs, vb, va}, exp_v);
            end
            c_hs += int'(hs); c_ha += int'(ha); c_vs += int'(vs); c_va += int'(va);
            c_da += int'(ha && va);
            cyc++;
        end
    end

    task automatic run_mode(input int hact, input int hsl, input int vact, input int vsl);
        int frames = 2;
        c_hs = 0; c_ha = 0; c_vs = 0; c_va = 0; c_da = 0; cyc = 0;
        keyed_write(4'd8, 32'h1);
        push_expect(frames * (m_ht + 1) * (m_vt + 1));
        while (sb_q.size() != 0) @(posedge clk);
        @(negedge clk);
        chk("R10 hsync cycles",  c_hs, frames * hsl * (m_vt + 1));
        chk("R10 hactive cycles", c_ha, frames * hact * (m_vt + 1));
        chk("R10 vsync cycles",  c_vs, frames * vsl * (m_ht + 1));
        chk("R10 vactive cycles", c_va, frames * vact * (m_ht + 1));
        chk("R10 display area",  c_da, frames * hact * vact);
        keyed_write(4'd8, 32'h0);
        @(posedge clk); #2;
        chk("R6 outputs low after disable", {26'b0, hs, hb, ha, vs, vb, va}, 32'h0);
        repeat (5) @(posedge clk); #2;
        chk("R6 outputs stay low", {26'b0, hs, hb, ha, vs, vb, va}, 32'h0);
    endtask

    initial begin
        #1000000;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 outputs low", {26'b0, hs, hb, ha, vs, vb, va}, 32'h0);
        for (int a = 0; a < 10; a++) begin
            bus_read(4'(a), d);
            chk("R1 reset register value", d, 32'h0);
        end

        bus_write(4'd0, 32'd14);
        bus_read(4'd0, d);
        chk("R2 write without key ignored", d, 32'h0);
        bus_write(4'd8, 32'h1);
        bus_read(4'd8, d);
        chk("R2 enable write without key ignored", d, 32'h0);

        bus_write(4'd9, 32'h55);
        bus_write(4'd0, 32'd14);
        bus_read(4'd0, d);
        chk("R4 wrong key does not open", d, 32'h0);
        bus_read(4'd9, d);
        chk("R4 gate still shut", d, 32'h0);

        bus_write(4'd9, 32'hAA);
        bus_read(4'd9, d);
        chk("R3 gate reads open", d, 32'h1);
        bus_read(4'd9, d);
        chk("R3 read closed the gate", d, 32'h0);

        bus_write(4'd9, 32'hAA);
        bus_read(4'd5, d);
        bus_write(4'd0, 32'd33);
        bus_read(4'd0, d);
        chk("R3 gate spent by read", d, 32'h0);

        keyed_write(4'd0, 32'h1234);
        bus_write(4'd0, 32'h55);
        bus_read(4'd0, d);
        chk("R3 second write after key ignored", d, 32'h1234);

        keyed_write(4'd1, 32'hABCD_1234);
        bus_read(4'd1, d);
        chk("R5 pair readback", d, 32'hABCD_1234);
        keyed_write(4'd7, 32'h0002_0009);
        bus_read(4'd7, d);
        chk("R5 vertical pair readback", d, 32'h0002_0009);
        keyed_write(4'd8, 32'hFFFF_FFF0);
        bus_read(4'd8, d);
        chk("R5 control only bit 0", d, 32'h0);

        program_mode(8, 2, 3, 2, 4, 1, 2, 1);
        bus_read(4'd2, d);
        chk("R5 blank pair programmed", d, {16'(m_hb_stop), 16'(m_hb_start)});
        run_mode(8, 2, 4, 1);

        program_mode(6, 1, 2, 3, 3, 2, 1, 2);
        run_mode(6, 3, 3, 2);

        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule